// File: doc/BRIEF.md
# Phase-Switched Pulse Integrator Bank with Serial Snapshot Readout

This block integrates the outputs of seventeen voltage-to-frequency converters. Each converter delivers an asynchronous pulse stream whose rate sits near 4 MHz and moves with its analog input. Every channel has its own 24-bit accumulator. On each pulse the accumulator steps up or down, and a shared phase-switch input picks the direction. That input is the demodulation signal, so the accumulated value is the difference between the two switch states.

A timer counts system clocks up to a programmed interval length. When it expires, all seventeen accumulators are copied into one 408-bit shift register in a single cycle. On that same cycle they restart for the next interval. The captured image then leaves serially, one bit for each serial-enable tick, with a data bit, a bit strobe and a frame flag. This happens while the next interval is already integrating. The system clock must run at least four times faster than the highest pulse rate.

Top module: `vfc_count_bank`

## Requirements
- R1: While reset is high, and in the cycle after it, ser_frame, ser_strobe, ser_data and overrun are 0. The first snapshot after reset reads all zeros when no pulse arrived.
- R2: Each rising edge of a channel's pulse input changes that channel's count by exactly one, however long the pulse stays high. With no rising edge and no expiry, the count holds.
- R3: phase_sw = 0 makes a detected pulse add one; phase_sw = 1 makes it subtract one.
- R4: Counts wrap modulo 2^24 in two's complement. One down-step from zero gives 0xFFFFFF.
- R5: A snapshot is taken every int_len system clocks, counted from reset or from the previous snapshot. A value of 0 behaves as 1.
- R6: On the snapshot cycle, the image holds the counts from before that cycle. A pulse detected in that same cycle starts the new interval at +1 or -1, and every other channel restarts at 0.
- R7: The image leaves channel 0 first, and within a channel the most significant bit first. Exactly one bit leaves per cycle in which ser_tick is high, and each bit is marked by a one-cycle ser_strobe.
- R8: ser_frame rises with the first strobe of an image and falls the cycle after the last. Without overrun it covers exactly 408 strobes, and ser_strobe is never high outside it.
- R9: If a snapshot is taken while bits of the previous image are still unsent, overrun goes high and stays high until reset. The new image replaces the unsent bits and starts again from its first bit.
- R10: ser_tick has no effect when no unsent bits are held: ser_strobe stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_in | input | 17 | Asynchronous converter pulse streams, one bit per channel |
| phase_sw | input | 1 | Count direction, synchronous: 0 up, 1 down |
| int_len | input | 32 | Integration interval length in system clocks |
| ser_tick | input | 1 | Serial enable: one bit is sent per high cycle |
| ser_data | output | 1 | Serial image bit |
| ser_strobe | output | 1 | High for one cycle with each valid ser_data bit |
| ser_frame | output | 1 | High across the strobes of one image |
| overrun | output | 1 | Sticky flag: a snapshot replaced unsent bits |

## Verification
On every clock, the assertions check channel 0's single-step behaviour in both directions, its hold when idle, and its restart value on the snapshot cycle. They also check the shifter's reload on expiry, that strobes stay inside a frame and follow a tick, and that the overrun flag is sticky. Only the bench's scenarios can show whole-image results. These are the serial bit order across all seventeen channels, the count of long pulses, the negative wrap, the snapshot period and the 408-strobe frame length. They also include the exact cycle at which a pulse moves from one interval to the next.

// File: rtl/vfc_pkg.sv
package vfc_pkg;

  typedef enum logic {
    CNT_UP   = 1'b0,
    CNT_DOWN = 1'b1
  } cnt_dir_e;

  // width of a counter able to hold the value n
  function automatic int bits_for(input int n);
    return $clog2(n + 1);
  endfunction

endpackage

// File: rtl/pulse_edge_sync.sv
module pulse_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);

  // sh[0..STAGES-1] are synchronizer flops, sh[STAGES] holds the previous level
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], async_in};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];

endmodule

// File: rtl/updown_acc.sv
module updown_acc
  import vfc_pkg::*;
#(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  cnt_dir_e     dir,
  input  logic         restart,
  output logic [W-1:0] value
);

  logic [W-1:0] delta;

  // two's complement step: +1 or all ones (-1)
  assign delta = (dir == CNT_DOWN) ? {W{1'b1}} : W'(1);

  always_ff @(posedge clk) begin
    if (rst)          value <= '0;
    else if (restart) value <= step ? delta : '0;
    else if (step)    value <= value + delta;
  end

endmodule

// File: rtl/integ_timer.sv
module integ_timer #(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] len,
  output logic          expire
);

  logic [TW-1:0] tmr;

  // elapsed + 1 reaches the programmed length; a length of 0 expires every cycle
  assign expire = ({1'b0, tmr} + {{TW{1'b0}}, 1'b1}) >= {1'b0, len};

  always_ff @(posedge clk) begin
    if (rst)         tmr <= '0;
    else if (expire) tmr <= '0;
    else             tmr <= tmr + 1'b1;
  end

endmodule

// File: rtl/snap_shifter.sv
module snap_shifter
  import vfc_pkg::*;
#(
  parameter int NBITS = 408,
  localparam int RW   = bits_for(NBITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [NBITS-1:0] load_data,
  input  logic             tick,
  output logic             ser_data,
  output logic             ser_strobe,
  output logic             ser_frame,
  output logic             overrun,
  output logic [RW-1:0]    remaining
);

  logic [NBITS-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr         <= '0;
      remaining  <= '0;
      ser_data   <= 1'b0;
      ser_strobe <= 1'b0;
      ser_frame  <= 1'b0;
      overrun    <= 1'b0;
    end else begin
      ser_strobe <= 1'b0;
      if (load) begin
        sr        <= load_data;
        remaining <= RW'(NBITS);
        if (remaining != '0) overrun   <= 1'b1;
        else                 ser_frame <= 1'b0;
      end else if (tick && remaining != '0) begin
        ser_data   <= sr[NBITS-1];
        sr         <= {sr[NBITS-2:0], 1'b0};
        remaining  <= remaining - 1'b1;
        ser_strobe <= 1'b1;
        ser_frame  <= 1'b1;
      end else if (remaining == '0) begin
        ser_frame  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/vfc_count_bank.sv
module vfc_count_bank
  import vfc_pkg::*;
#(
  parameter int NCH         = 17,
  parameter int CW          = 24,
  parameter int TW          = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] pulse_in,
  input  logic           phase_sw,
  input  logic [TW-1:0]  int_len,
  input  logic           ser_tick,
  output logic           ser_data,
  output logic           ser_strobe,
  output logic           ser_frame,
  output logic           overrun
);

  localparam int NBITS = NCH * CW;
  localparam int RW    = bits_for(NBITS);

  logic [NCH-1:0]   rise;
  logic             expire;
  logic [NBITS-1:0] snap_bus;
  logic [RW-1:0]    remaining;
  cnt_dir_e         dir;

  assign dir = phase_sw ? CNT_DOWN : CNT_UP;

  // channel 0 occupies the top slice so it is shifted out first
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pulse_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst      (rst),
      .async_in (pulse_in[g]),
      .rise     (rise[g])
    );

    updown_acc #(.W(CW)) u_acc (
      .clk     (clk),
      .rst     (rst),
      .step    (rise[g]),
      .dir     (dir),
      .restart (expire),
      .value   (snap_bus[NBITS-1-g*CW -: CW])
    );
  end

  integ_timer #(.TW(TW)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .len    (int_len),
    .expire (expire)
  );

  snap_shifter #(.NBITS(NBITS)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .load       (expire),
    .load_data  (snap_bus),
    .tick       (ser_tick),
    .ser_data   (ser_data),
    .ser_strobe (ser_strobe),
    .ser_frame  (ser_frame),
    .overrun    (overrun),
    .remaining  (remaining)
  );

endmodule

// File: rtl/vfc_count_bank_chk.sv
module vfc_count_bank_chk #(
  parameter int CW    = 24,
  parameter int NBITS = 408,
  parameter int RW    = 9
) (
  input logic          clk,
  input logic          rst,
  input logic          phase_sw,
  input logic          ser_tick,
  input logic          rise0,
  input logic          expire,
  input logic [CW-1:0] ch0,
  input logic [RW-1:0] remaining,
  input logic          ser_strobe,
  input logic          ser_frame,
  input logic          overrun
);

  AST_RST_IDLE: assert property (@(posedge clk)
    rst |=> (!ser_frame && !ser_strobe && !overrun && remaining == '0)); // R1

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!expire && !rise0) |=> $stable(ch0)); // R2

  AST_UP_STEP: assert property (@(posedge clk) disable iff (rst)
    (!expire && rise0 && !phase_sw) |=> (ch0 == $past(ch0) + CW'(1))); // R3

  AST_DOWN_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!expire && rise0 && phase_sw) |=> (ch0 == $past(ch0) - CW'(1))); // R4

  AST_RELOAD: assert property (@(posedge clk) disable iff (rst)
    expire |=> (remaining == RW'(NBITS))); // R5

  AST_NEW_INTERVAL: assert property (@(posedge clk) disable iff (rst)
    expire |=> (ch0 == ($past(rise0) ? ($past(phase_sw) ? {CW{1'b1}} : CW'(1)) : '0))); // R6

  AST_STROBE_TICK: assert property (@(posedge clk) disable iff (rst)
    ser_strobe |-> $past(ser_tick)); // R7

  AST_STROBE_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    ser_strobe |-> ser_frame); // R8

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun); // R9

  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    (remaining == '0 && !expire) |=> !ser_strobe); // R10

endmodule

bind vfc_count_bank vfc_count_bank_chk #(
  .CW    (CW),
  .NBITS (NBITS),
  .RW    (RW)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .phase_sw   (phase_sw),
  .ser_tick   (ser_tick),
  .rise0      (rise[0]),
  .expire     (expire),
  .ch0        (snap_bus[NBITS-1 -: CW]),
  .remaining  (remaining),
  .ser_strobe (ser_strobe),
  .ser_frame  (ser_frame),
  .overrun    (overrun)
);

// File: tb/test_vfc_count_bank.sv
module test_vfc_count_bank;

  localparam int NCH = 17;
  localparam int CW  = 24;
  localparam int NB  = NCH * CW;
  localparam int LEN = 2000;
  localparam int NV  = 6;

  // {up base, down count, pulse width}; channel c gets (up base + c) up pulses
  localparam logic [23:0] VEC [NV] = '{
    {8'd5,  8'd0,  8'd2},
    {8'd0,  8'd3,  8'd2},
    {8'd10, 8'd20, 8'd2},
    {8'd0,  8'd20, 8'd2},
    {8'd3,  8'd1,  8'd9},
    {8'd0,  8'd0,  8'd2}
  };

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NCH-1:0] pulse_in = '0;
  logic           phase_sw = 1'b0;
  logic [31:0]    int_len = LEN;
  logic           ser_tick = 1'b0;
  logic           ser_data, ser_strobe, ser_frame, overrun;

  vfc_count_bank i_vfc_count_bank (
    .clk        (clk),
    .rst        (rst),
    .pulse_in   (pulse_in),
    .phase_sw   (phase_sw),
    .int_len    (int_len),
    .ser_tick   (ser_tick),
    .ser_data   (ser_data),
    .ser_strobe (ser_strobe),
    .ser_frame  (ser_frame),
    .overrun    (overrun)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] chan(input logic [NB-1:0] f, input int c);
    return f[NB-1-c*CW -: CW];
  endfunction

  // monitor: samples at the falling edge
  int starts = 0, done = 0, nbits = 0, cyc = 0, last_start = 0;
  bit period_chk = 1;
  logic prev_frame = 1'b0;
  logic [NB-1:0] buf_r = '0;
  logic [NB-1:0] frame_q = '0;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (ser_frame && !prev_frame) begin
        starts++;
        nbits = 0;
        if (period_chk && starts >= 2)
          chk(cyc - last_start == LEN, "R5 snapshot period", cyc - last_start, LEN);
        last_start = cyc;
      end
      if (ser_strobe) begin
        buf_r = {buf_r[NB-2:0], ser_data};
        nbits++;
        if (nbits == NB) begin
          frame_q = buf_r;
          done++;
        end
      end
      if (!ser_frame && prev_frame && !overrun)
        chk(nbits == NB, "R8 strobes per frame", nbits, NB);
      prev_frame = ser_frame;
    end
  end

  task automatic tickn(input int n);
    repeat (n) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic wait_start();
    int s;
    s = starts;
    while (starts == s) tickn(1);
  endtask

  task automatic wait_done(input int d);
    while (done < d) tickn(1);
  endtask

  task automatic burst(input int nup, input int ndn, input int w);
    phase_sw = 1'b0;
    for (int k = 0; k < nup + NCH; k++) begin
      for (int c = 0; c < NCH; c++) pulse_in[c] = (nup + c > k);
      tickn(w);
      pulse_in = '0;
      tickn(3);
    end
    tickn(4);
    phase_sw = 1'b1;
    for (int k = 0; k < ndn; k++) begin
      pulse_in = '1;
      tickn(w);
      pulse_in = '0;
      tickn(3);
    end
    tickn(4);
    phase_sw = 1'b0;
  endtask

  initial begin
    int s;
    int nstrobe;
    logic [CW-1:0] e;

    // R1: reset state
    ser_tick = 1'b1;
    tickn(5);
    chk(!ser_frame && !ser_strobe && !ser_data && !overrun, "R1 outputs in reset",
        {ser_frame, ser_strobe, ser_data, overrun}, 0);
    rst = 1'b0;
    tickn(1);
    chk(!ser_frame && !ser_strobe && !overrun, "R1 outputs after reset",
        {ser_frame, ser_strobe, overrun}, 0);

    // R10: ticks with nothing loaded give no strobes
    nstrobe = 0;
    for (int i = 0; i < 100; i++) begin
      if (ser_strobe) nstrobe++;
      tickn(1);
    end
    chk(nstrobe == 0, "R10 ticks while idle", nstrobe, 0);

    // R1: first image is all zero
    wait_start();
    wait_done(1);
    chk(frame_q == '0, "R1 first image zero", frame_q[63:0], 0);

    // table walk: R2 R3 R4 R7
    for (int v = 0; v < NV; v++) begin
      int nup, ndn, w;
      nup = int'(VEC[v][23:16]);
      ndn = int'(VEC[v][15:8]);
      w   = int'(VEC[v][7:0]);
      wait_start();
      s = starts;
      burst(nup, ndn, w);
      wait_done(s + 1);
      for (int c = 0; c < NCH; c++) begin
        e = CW'(nup + c - ndn);
        chk(chan(frame_q, c) == e, $sformatf("R2 R3 R4 R7 vec%0d ch%0d", v, c),
            chan(frame_q, c), e);
      end
    end

    // R6: pulses straddling the snapshot cycle
    wait_start();
    s = starts;
    pulse_in = 17'h00001;
    tickn(2);
    pulse_in = '0;
    tickn(LEN - 7);
    pulse_in = 17'h00004;
    tickn(1);
    pulse_in = 17'h00006;
    tickn(3);
    pulse_in = '0;
    wait_done(s + 1);
    chk(chan(frame_q, 0) == 24'd1, "R6 early pulse ch0", chan(frame_q, 0), 1);
    chk(chan(frame_q, 2) == 24'd1, "R6 pulse before snapshot ch2", chan(frame_q, 2), 1);
    chk(chan(frame_q, 1) == 24'd0, "R6 pulse on snapshot cycle leaves old image", chan(frame_q, 1), 0);
    wait_done(s + 2);
    chk(chan(frame_q, 1) == 24'd1, "R6 pulse on snapshot cycle counts in new interval",
        chan(frame_q, 1), 1);
    chk(chan(frame_q, 0) == 24'd0 && chan(frame_q, 2) == 24'd0, "R6 others restart at zero",
        {chan(frame_q, 0), chan(frame_q, 2)}, 0);

    // R9: snapshot interval shorter than the scan
    chk(overrun == 1'b0, "R9 no overrun at normal rate", overrun, 0);
    period_chk = 0;
    int_len = 300;
    tickn(1500);
    chk(overrun == 1'b1, "R9 overrun raised", overrun, 1);
    int_len = LEN;
    tickn(50);
    chk(overrun == 1'b1, "R9 overrun sticky", overrun, 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule